// File: doc/BRIEF.md
# Octal Double-Buffered Channel Register Command Decoder

This block sits behind a serial receiver and takes one 16-bit command word per strobe. It turns each word into register operations on eight channels. Each channel holds a staging (input) register and a live (output) register of eight bits each. The live registers drive the converter codes. The block also keeps a per-channel output-enable bit and a one-bit setting that picks the edge on which an upstream shift register emits data.

A separate active-low load pin can be asserted at any time. The block synchronizes it into the system clock. While the synchronized pin is low, every live register follows its staging register on every cycle, so a staging write shows at the output straight away. A system controller uses the block in two ways. It can preload staging registers and commit them all at once with a transfer command or the pin. Or it can write a single channel through to its output.

Top module: `octal_bank_ctrl`

## Requirements
- R1: Control code 000 (no-op) changes no staging register, no live register, no enable bit and no phase bit.
- R2: Control code 001 sets every staging and live register to zero and sets all eight enable bits to 1.
- R3: Control code 010 copies data bit i into the enable bit of channel i (bit 0 goes to channel 0). All-zero data disables every channel. Register contents do not change.
- R4: Control code 011 loads the phase bit from the top address bit (0 = falling edge, 1 = rising edge) and copies every staging register into its live register. No other code changes the phase bit.
- R5: Control code 100 writes the data byte into all eight live registers and sets all enable bits to 1. Staging registers stay unchanged.
- R6: Control code 101 writes the data byte into the staging register chosen by the 3-bit address. No live register changes.
- R7: Control code 110 writes the data byte into both the staging and the live register of the addressed channel. Other channels stay unchanged.
- R8: Enable bits go to all-ones only on codes 001, 100 and 110. Codes 101, 111 and 011 leave them as they were.
- R9: Control code 111 copies every staging register into its live register.
- R10: The load pin passes through a two-flop synchronizer. The live registers begin to follow their staging registers on the third clock edge after the pin falls. While the pin is low, a staging write (or the broadcast of R5, which then loses priority) leaves each live register equal to its staging register one edge after the strobe. Once the pin is high again and synchronized, the live registers hold.
- R11: After reset, all registers read zero, all enable bits read 1 and the phase bit reads 0 (falling edge).
- R12: Word layout: bits 15:14 are ignored, 13:11 hold the channel address, 10:8 the control code and 7:0 the data. A word is acted on at the clock edge where the strobe is sampled high, and its results are visible after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | Strobe: word_in holds a command this cycle |
| word_in | input | 16 | Command word (pad, address, control, data) |
| load_n | input | 1 | Asynchronous active-low load pin |
| dac_q | output | 64 | Live registers; channel i at bits [8i+7:8i] |
| chan_en | output | 8 | Per-channel output enable, bit i for channel i |
| phase_rise | output | 1 | Data-out phase: 1 = rising edge, 0 = falling edge |

## Verification
The bench builds the block with its default parameters: eight channels of eight bits, two pad bits and a two-stage synchronizer. With these values, the full 3-bit address space maps onto real channels, and a shutdown mask bit exists for every channel. The synchronizer latency of R10 is then exactly two edges plus one update edge, so it can be checked on a fixed cycle. These settings let directed words cover every control code, both phase settings, the all-zero shutdown mask, nonzero pad bits, and every command issued while the load pin holds the outputs transparent.

// File: rtl/octal_bank_pkg.sv
// Shared types for the channel register command decoder.
// Assumes the control field is three bits wide with fixed code values.
package octal_bank_pkg;

    typedef enum logic [2:0] {
        CMD_NOP       = 3'b000,
        CMD_CLEAR     = 3'b001,
        CMD_SHUTDOWN  = 3'b010,
        CMD_PHASE     = 3'b011,
        CMD_BROADCAST = 3'b100,
        CMD_STAGE     = 3'b101,
        CMD_WRITE_BOTH= 3'b110,
        CMD_COMMIT    = 3'b111
    } cmd_e;

    // Decoded strobe-qualified operations for one word.
    typedef struct packed {
        logic clear_all;
        logic stage_wr;
        logic both_wr;
        logic broadcast;
        logic commit_all;
        logic shutdown;
        logic wake;
        logic set_phase;
    } op_s;

endpackage

// File: rtl/load_sync.sv
// Synchronizes the asynchronous active-low load pin into clk.
// Assumes STAGES >= 2; resets to the inactive (high) level.
module load_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin through the synchronizer flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_n};
    end

    assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cmd_decode.sv
// Splits a command word into fields and qualifies each operation with
// the strobe. Assumes NUM_CH is a power of two and at least 2.
module cmd_decode
    import octal_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DW     = 8,
    parameter int PAD_W  = 2,
    localparam int AW     = $clog2(NUM_CH),
    localparam int WORD_W = PAD_W + AW + 3 + DW
) (
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    output op_s               op_o,
    output logic [NUM_CH-1:0] sel_o,
    output logic [DW-1:0]     data_o,
    output logic              phase_bit_o
);
    localparam int CTRL_LSB = DW;
    localparam int ADDR_LSB = DW + 3;

    logic [2:0]    cmd;
    logic [AW-1:0] addr;
    logic          unused_pad;

    assign cmd         = word_i[CTRL_LSB +: 3];
    assign addr        = word_i[ADDR_LSB +: AW];
    assign data_o      = word_i[DW-1:0];
    assign phase_bit_o = addr[AW-1];
    assign unused_pad  = ^word_i[WORD_W-1 -: PAD_W];

    // One-hot channel select from the address field.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        assign sel_o[i] = (addr == AW'(i));
    end

    // Map the control code to strobe-qualified operations.
    always_comb begin
        op_o = '0;
        if (valid_i) begin
            unique case (cmd_e'(cmd))
                CMD_NOP:        ;
                CMD_CLEAR:      begin op_o.clear_all = 1'b1; op_o.wake = 1'b1; end
                CMD_SHUTDOWN:   op_o.shutdown = 1'b1;
                CMD_PHASE:      begin op_o.set_phase = 1'b1; op_o.commit_all = 1'b1; end
                CMD_BROADCAST:  begin op_o.broadcast = 1'b1; op_o.wake = 1'b1; end
                CMD_STAGE:      op_o.stage_wr = 1'b1;
                CMD_WRITE_BOTH: begin op_o.both_wr = 1'b1; op_o.wake = 1'b1; end
                CMD_COMMIT:     op_o.commit_all = 1'b1;
                default:        ;
            endcase
        end
    end
endmodule

// File: rtl/chan_slice.sv
// One channel: a staging register and a live register.
// Assumes at most one of the write controls is active per cycle,
// apart from transparency, which overrides all but clear.
module chan_slice #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          stage_wr_i,
    input  logic          live_wr_i,
    input  logic          broadcast_i,
    input  logic          commit_i,
    input  logic          transparent_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] live_o
);
    logic [DW-1:0] stage_q;
    logic [DW-1:0] stage_nx;

    // Next staging value from clear or write.
    always_comb begin
        if (clear_i)         stage_nx = '0;
        else if (stage_wr_i) stage_nx = data_i;
        else                 stage_nx = stage_q;
    end

    // Staging register update.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_nx;
    end

    // Live register update with transparency taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)             live_o <= '0;
        else if (clear_i)       live_o <= '0;
        else if (transparent_i) live_o <= stage_nx;
        else if (broadcast_i)   live_o <= data_i;
        else if (live_wr_i)     live_o <= data_i;
        else if (commit_i)      live_o <= stage_q;
    end
endmodule

// File: rtl/mode_state.sv
// Holds the per-channel enable bits and the data-out phase bit.
// Assumes data bit i drives channel i's enable during shutdown.
module mode_state
    import octal_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_s               op_i,
    input  logic [DW-1:0]     data_i,
    input  logic              phase_bit_i,
    output logic [NUM_CH-1:0] en_o,
    output logic              phase_o
);
    logic [NUM_CH-1:0] mask;

    // Shutdown mask; channels without a data bit are disabled.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_mask
        if (i < DW) begin : g_bit
            assign mask[i] = data_i[i];
        end else begin : g_zero
            assign mask[i] = 1'b0;
        end
    end

    // Enable bits: shutdown loads the mask, wake sets all.
    always_ff @(posedge clk) begin
        if (!rst_n)            en_o <= '1;
        else if (op_i.shutdown) en_o <= mask;
        else if (op_i.wake)     en_o <= '1;
    end

    // Phase bit follows only the phase command.
    always_ff @(posedge clk) begin
        if (!rst_n)              phase_o <= 1'b0;
        else if (op_i.set_phase) phase_o <= phase_bit_i;
    end
endmodule

// File: rtl/octal_bank_ctrl.sv
// Top: decodes strobed command words into channel register operations,
// tracks enables and phase, and applies the synchronized load pin.
// Assumes words arrive already deserialized, one per strobe.
module octal_bank_ctrl
    import octal_bank_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int DW          = 8,
    parameter int PAD_W       = 2,
    parameter int SYNC_STAGES = 2,
    localparam int AW     = $clog2(NUM_CH),
    localparam int WORD_W = PAD_W + AW + 3 + DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_valid,
    input  logic [WORD_W-1:0]    word_in,
    input  logic                 load_n,
    output logic [NUM_CH*DW-1:0] dac_q,
    output logic [NUM_CH-1:0]    chan_en,
    output logic                 phase_rise
);
    op_s               op;
    logic [NUM_CH-1:0] sel;
    logic [DW-1:0]     data;
    logic              phase_bit;
    logic              ld_sync_n;

    load_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_n(load_n), .sync_n(ld_sync_n)
    );

    cmd_decode #(.NUM_CH(NUM_CH), .DW(DW), .PAD_W(PAD_W)) u_dec (
        .valid_i(word_valid), .word_i(word_in), .op_o(op),
        .sel_o(sel), .data_o(data), .phase_bit_o(phase_bit)
    );

    mode_state #(.NUM_CH(NUM_CH), .DW(DW)) u_mode (
        .clk(clk), .rst_n(rst_n), .op_i(op), .data_i(data),
        .phase_bit_i(phase_bit), .en_o(chan_en), .phase_o(phase_rise)
    );

    // One slice per channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        chan_slice #(.DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .clear_i(op.clear_all),
            .stage_wr_i((op.stage_wr | op.both_wr) & sel[i]),
            .live_wr_i(op.both_wr & sel[i]),
            .broadcast_i(op.broadcast),
            .commit_i(op.commit_all),
            .transparent_i(~ld_sync_n),
            .data_i(data),
            .live_o(dac_q[i*DW +: DW])
        );
    end
endmodule

// File: rtl/octal_bank_checker.sv
// Temporal checks on the top module's ports and synchronized load level.
// Assumes the default word layout: data low, control above, address above that.
module octal_bank_checker #(
    parameter int NUM_CH = 8,
    parameter int DW     = 8,
    parameter int WORD_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 word_valid,
    input logic [WORD_W-1:0]    word_in,
    input logic                 ld_sync_n,
    input logic [NUM_CH*DW-1:0] dac_q,
    input logic [NUM_CH-1:0]    chan_en,
    input logic                 phase_rise
);
    localparam int AW = $clog2(NUM_CH);
    logic [2:0]    cmd;
    logic [AW-1:0] addr;
    logic          unused_pad;
    assign cmd        = word_in[DW +: 3];
    assign addr       = word_in[DW+3 +: AW];
    assign unused_pad = ^word_in[WORD_W-1:DW+3+AW];

    assert_nop_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && cmd == 3'b000 && ld_sync_n) |=>
        ($stable(dac_q) && $stable(chan_en) && $stable(phase_rise)));

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && cmd == 3'b001) |=> (dac_q == '0 && chan_en == '1));

    assert_shutdown_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && cmd == 3'b010) |=> (chan_en == $past(word_in[NUM_CH-1:0])));

    assert_phase_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && cmd == 3'b011) |=> (phase_rise == $past(addr[AW-1])));

    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_valid && cmd == 3'b011) |=> $stable(phase_rise));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_bc
        assert_broadcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (word_valid && cmd == 3'b100 && ld_sync_n) |=>
            (dac_q[i*DW +: DW] == $past(word_in[DW-1:0])));
    end

    assert_stage_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && cmd == 3'b101 && ld_sync_n) |=> $stable(dac_q));

    assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && (cmd == 3'b100 || cmd == 3'b110)) |=> (chan_en == '1));

    assert_no_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && (cmd == 3'b101 || cmd == 3'b111 || cmd == 3'b011)) |=> $stable(chan_en));
endmodule

bind octal_bank_ctrl octal_bank_checker #(
    .NUM_CH(NUM_CH), .DW(DW), .WORD_W(WORD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
    .ld_sync_n(ld_sync_n), .dac_q(dac_q), .chan_en(chan_en),
    .phase_rise(phase_rise)
);

// File: tb/sim_octal_bank_ctrl.sv
// Directed bench: one task per scenario, each checking against a model
// built from the requirements.
module sim_octal_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word_in = '0;
    logic        load_n = 1'b1;
    logic [63:0] dac_q;
    logic [7:0]  chan_en;
    logic        phase_rise;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] m_in  [8];
    logic [7:0] m_out [8];
    logic [7:0] m_en;
    logic       m_phase;
    logic       m_transp;

    always #2 clk = ~clk;

    octal_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
        .load_n(load_n), .dac_q(dac_q), .chan_en(chan_en), .phase_rise(phase_rise)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: got %0d cycles exp < 20000", cycles);
            finish_run();
        end
    end

    task automatic model(input int addr, input logic [2:0] cmd, input logic [7:0] d);
        case (cmd)
            3'b001: begin
                for (int i = 0; i < 8; i++) begin m_in[i] = 0; m_out[i] = 0; end
                m_en = 8'hFF;
            end
            3'b010: m_en = d;
            3'b011: begin
                m_phase = addr[2];
                for (int i = 0; i < 8; i++) m_out[i] = m_in[i];
            end
            3'b100: begin
                for (int i = 0; i < 8; i++) m_out[i] = d;
                m_en = 8'hFF;
            end
            3'b101: m_in[addr] = d;
            3'b110: begin m_in[addr] = d; m_out[addr] = d; m_en = 8'hFF; end
            3'b111: for (int i = 0; i < 8; i++) m_out[i] = m_in[i];
            default: ;
        endcase
        if (m_transp) for (int i = 0; i < 8; i++) m_out[i] = m_in[i];
    endtask

    task automatic send(input logic [1:0] pad, input int addr,
                        input logic [2:0] cmd, input logic [7:0] d);
        @(negedge clk);
        word_valid = 1'b1;
        word_in = {pad, addr[2:0], cmd, d};
        @(posedge clk);
        model(addr, cmd, d);
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            checks++;
            if (dac_q[i*8 +: 8] !== m_out[i]) begin
                errors++;
                $display("FAIL %s ch%0d dac: got %h exp %h", tag, i, dac_q[i*8 +: 8], m_out[i]);
            end
        end
        checks++;
        if (chan_en !== m_en) begin
            errors++;
            $display("FAIL %s enable: got %h exp %h", tag, chan_en, m_en);
        end
        checks++;
        if (phase_rise !== m_phase) begin
            errors++;
            $display("FAIL %s phase: got %b exp %b", tag, phase_rise, m_phase);
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) begin m_in[i] = 0; m_out[i] = 0; end
        m_en = 8'hFF; m_phase = 1'b0; m_transp = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R11");
    endtask

    task automatic t_stage_then_commit();
        for (int i = 0; i < 8; i++) begin
            send(2'(i), i, 3'b101, 8'(8'h11 * (i + 1)));
            check_all("R6 R12");
        end
        send(2'b10, 0, 3'b111, 8'h5A);
        check_all("R9");
    endtask

    task automatic t_write_both();
        send(2'b11, 3, 3'b110, 8'hA5);
        check_all("R7");
        send(2'b00, 7, 3'b110, 8'h0F);
        check_all("R7");
    endtask

    task automatic t_shutdown();
        send(2'b00, 0, 3'b010, 8'b1010_0101);
        check_all("R3");
        send(2'b00, 2, 3'b101, 8'hC3);
        check_all("R8 stage");
        send(2'b00, 0, 3'b111, 8'h00);
        check_all("R8 commit");
        send(2'b00, 1, 3'b110, 8'h42);
        check_all("R8 wake");
        send(2'b00, 5, 3'b010, 8'h00);
        check_all("R3 all off");
        send(2'b00, 0, 3'b100, 8'h3C);
        check_all("R5 R8");
    endtask

    task automatic t_phase();
        send(2'b00, 0, 3'b101, 8'h01);
        send(2'b00, 4, 3'b011, 8'hEE);
        check_all("R4 rise");
        send(2'b00, 6, 3'b101, 8'h66);
        send(2'b00, 3, 3'b011, 8'h00);
        check_all("R4 fall");
    endtask

    task automatic t_nop();
        send(2'b11, 5, 3'b000, 8'hFF);
        check_all("R1");
        send(2'b01, 2, 3'b000, 8'h00);
        check_all("R1");
    endtask

    task automatic t_clear();
        send(2'b00, 0, 3'b010, 8'h0F);
        send(2'b00, 6, 3'b001, 8'hAB);
        check_all("R2");
        send(2'b00, 0, 3'b111, 8'h00);
        check_all("R2 staging cleared");
    endtask

    task automatic t_load_pin();
        send(2'b00, 1, 3'b101, 8'h21);
        send(2'b00, 4, 3'b101, 8'h44);
        check_all("R10 pre");
        @(negedge clk);
        load_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check_all("R10 latency hold");
        @(posedge clk);
        for (int i = 0; i < 8; i++) m_out[i] = m_in[i];
        m_transp = 1'b1;
        @(negedge clk);
        check_all("R10 follow");
        send(2'b00, 5, 3'b101, 8'h77);
        check_all("R10 stage write");
        send(2'b00, 0, 3'b100, 8'h99);
        check_all("R10 broadcast");
        @(negedge clk);
        load_n = 1'b1;
        repeat (3) @(negedge clk);
        m_transp = 1'b0;
        send(2'b00, 2, 3'b101, 8'h2D);
        check_all("R10 frozen");
    endtask

    initial begin
        t_reset();
        t_stage_then_commit();
        t_write_both();
        t_shutdown();
        t_phase();
        t_nop();
        t_clear();
        t_load_pin();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule